// File: doc/BRIEF.md
# Interrupt controller register block

This block is a small register file on a 32-bit memory-mapped bus that gathers six interrupt sources into one interrupt line for a processor. It holds four word registers: a mode register, a fixed version word, an interrupt-pending register and an interrupt-enable (mask) register. The bus is a single-cycle port with an address, a write strobe, write data, a per-bit write mask and read data. Read data is combinational from the address.

The mode and mask registers are not loaded directly from the written data. The written word is first ANDed with the write mask. Its bits then act as commands, one clear bit and one set bit per flag. Within one write the clear is applied first, so a word that asserts both leaves the flag set.

A rising edge on a request input latches that source's pending bit. Sources 0 to 4 are released by a per-source acknowledge input. The display source (source 5) is released by a command bit in the mode register. The interrupt output is the registered OR of pending AND mask.

Top module: `irq_regblk`

## Requirements
- R1: After reset the mode, pending and mask registers read zero, `irq_out` is low, and the version word reads the `VERSION` parameter.
- R2: Address bits 31:29 are ignored. With the other bits, the mode register is at base 0x04300000 + 0x0, the version at +0x4, pending at +0x8 and mask at +0xC. `bus_rdata` shows the addressed register in the same cycle.
- R3: Write data is ANDed with `bus_wmask` before any bit of it is acted on.
- R4: A mode write replaces mode bits 6:0 with masked data bits 6:0. The mode register reads the init flag at bit 7, the external-bus flag at bit 8 and the memory-register flag at bit 9, and zero above bit 9.
- R5: The mode command bits are: clear-init 7, set-init 8, clear-external-bus 9, set-external-bus 10, clear-memory-register 12, set-memory-register 13. Clear is applied before set, so set wins when both are given. A flag with neither bit keeps its value.
- R6: A mode write with masked bit 11 set clears pending bit 5 (display source). A rising edge on `irq_req[5]` in the same cycle wins, and the bit stays set.
- R7: A mask write controls source i through bit 2i (clear) and bit 2i+1 (set), and set wins when both are given. Sources with neither bit keep their value. The mask reads at bits 5:0 in source order.
- R8: A rising edge on `irq_req[i]` sets pending bit i at the next clock edge. A request held high does not set the bit again after it has been cleared.
- R9: `irq_ack[i]` (i = 0..4) clears pending bit i. A rising edge of the same source in the same cycle wins, and the bit stays set.
- R10: `irq_out` is high one clock after any bit of pending AND mask is set, and low one clock after none is set.
- R11: Reads of unmapped addresses return zero. Writes to the version offset, the pending offset or an unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write mask |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_req | input | 6 | Interrupt requests, one per source |
| irq_ack | input | 5 | Pending-bit clears for sources 0..4 |
| irq_out | output | 1 | Combined interrupt |

## Verification
The mask and the pending set are swept together over all 64 × 64 patterns. This shows whether each source's enable gates only its own pending bit in the interrupt output. The seven mode command bits are swept over all 128 combinations against all eight starting flag states. This separates clear-then-set order, flags left untouched, and the display clear, with a fresh display edge before each step. Directed cases then cover:
- a rising edge coinciding with an acknowledge or with the display clear;
- a request held high;
- the write mask gating command bits;
- mirrored and unmapped addresses.

// File: rtl/irq_regblk_pkg.sv
package irq_regblk_pkg;
  localparam logic [31:0] ADDR_KEEP = 32'h1FFF_FFFF;
  localparam logic [31:0] OFS_MODE  = 32'h0;
  localparam logic [31:0] OFS_VER   = 32'h4;
  localparam logic [31:0] OFS_PEND  = 32'h8;
  localparam logic [31:0] OFS_MASK  = 32'hC;

  localparam int unsigned MODE_DATA_W = 7;
  localparam int unsigned MODE_FLAG_N = 3;

  // mode command bit positions
  localparam int unsigned MC_CLR_INIT = 7;
  localparam int unsigned MC_SET_INIT = 8;
  localparam int unsigned MC_CLR_XBUS = 9;
  localparam int unsigned MC_SET_XBUS = 10;
  localparam int unsigned MC_CLR_DISP = 11;
  localparam int unsigned MC_CLR_MREG = 12;
  localparam int unsigned MC_SET_MREG = 13;
  localparam int unsigned MODE_CMD_W  = 14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_VER,
    SEL_PEND,
    SEL_MASK
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_regblk_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0430_0000
) (
  input  logic [31:0] addr,
  output reg_sel_e    sel
);
  logic [31:0] addr_eff;

  assign addr_eff = addr & ADDR_KEEP;

  always_comb begin
    if      (addr_eff == BASE_ADDR + OFS_MODE) sel = SEL_MODE;
    else if (addr_eff == BASE_ADDR + OFS_VER)  sel = SEL_VER;
    else if (addr_eff == BASE_ADDR + OFS_PEND) sel = SEL_PEND;
    else if (addr_eff == BASE_ADDR + OFS_MASK) sel = SEL_MASK;
    else                                       sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_cmd_flags.sv
module irq_cmd_flags #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  logic [N-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (en) q_d = (q_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] req_q;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] edge_s;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign edge_s[i] = req[i] & ~req_q[i];
    always_comb begin
      pend_d[i] = pend_q[i];
      if (clr[i])    pend_d[i] = 1'b0;
      if (edge_s[i]) pend_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_regblk.sv
module irq_regblk
  import irq_regblk_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 6,
  parameter logic [31:0] BASE_ADDR = 32'h0430_0000,
  parameter logic [31:0] VERSION   = 32'h0001_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic [31:0]        bus_wmask,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-2:0] irq_ack,
  output logic               irq_out
);
  localparam int unsigned DISP  = NUM_SRC - 1;
  localparam int unsigned CMD_W = (2 * NUM_SRC > MODE_CMD_W) ? 2 * NUM_SRC : MODE_CMD_W;
  localparam int unsigned MODE_W = MODE_DATA_W + MODE_FLAG_N;

  logic                   rst_sync_n;
  reg_sel_e               dec_sel;
  logic [CMD_W-1:0]       wd;
  logic                   wr_mode, wr_mask;
  logic [MODE_DATA_W-1:0] mode_data_q, mode_data_d;
  logic [MODE_FLAG_N-1:0] mode_flags_q;
  logic [MODE_FLAG_N-1:0] mf_clr, mf_set;
  logic [NUM_SRC-1:0]     mask_q, mk_clr, mk_set;
  logic [NUM_SRC-1:0]     pend_q, pend_clr;
  logic                   irq_q, irq_d;

  irq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_addr_dec #(.BASE_ADDR(BASE_ADDR)) u_dec (
    .addr (bus_addr),
    .sel  (dec_sel)
  );

  // command bits only ever come from data gated by the write mask
  assign wd      = CMD_W'(bus_wdata & bus_wmask);
  assign wr_mode = bus_wr && (dec_sel == SEL_MODE);
  assign wr_mask = bus_wr && (dec_sel == SEL_MASK);

  // mode data field
  always_comb begin
    mode_data_d = mode_data_q;
    if (wr_mode) mode_data_d = wd[MODE_DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_data_q <= '0;
    else             mode_data_q <= mode_data_d;
  end

  // mode flags: [0] init, [1] external bus, [2] memory register
  assign mf_clr = {wd[MC_CLR_MREG], wd[MC_CLR_XBUS], wd[MC_CLR_INIT]};
  assign mf_set = {wd[MC_SET_MREG], wd[MC_SET_XBUS], wd[MC_SET_INIT]};

  irq_cmd_flags #(.N(MODE_FLAG_N)) u_mode_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (wr_mode),
    .clr   (mf_clr),
    .set   (mf_set),
    .q     (mode_flags_q)
  );

  // mask command pairs
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask_cmd
    assign mk_clr[i] = wd[2*i];
    assign mk_set[i] = wd[2*i+1];
  end

  irq_cmd_flags #(.N(NUM_SRC)) u_mask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (wr_mask),
    .clr   (mk_clr),
    .set   (mk_set),
    .q     (mask_q)
  );

  // pending: display source cleared from the mode register, others by ack
  assign pend_clr[DISP]   = wr_mode & wd[MC_CLR_DISP];
  assign pend_clr[DISP-1:0] = irq_ack;

  irq_pending #(.N(NUM_SRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (irq_req),
    .clr   (pend_clr),
    .pend  (pend_q)
  );

  // combined interrupt
  assign irq_d = |(pend_q & mask_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_out = irq_q;

  // read mux
  always_comb begin
    unique case (dec_sel)
      SEL_MODE: bus_rdata = {{(32-MODE_W){1'b0}}, mode_flags_q, mode_data_q};
      SEL_VER:  bus_rdata = VERSION;
      SEL_PEND: bus_rdata = {{(32-NUM_SRC){1'b0}}, pend_q};
      SEL_MASK: bus_rdata = {{(32-NUM_SRC){1'b0}}, mask_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_regblk_chk.sv
module irq_regblk_chk
  import irq_regblk_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_wmask,
  input logic [31:0]        bus_rdata,
  input reg_sel_e           sel,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] mask,
  input logic [2:0]         flags,
  input logic               irq_out
);
  localparam int unsigned DISP = NUM_SRC - 1;

  logic [31:0] cwd;
  logic        mode_wr;
  assign cwd     = bus_wdata & bus_wmask;
  assign mode_wr = bus_wr && (sel == SEL_MODE);

  // R10: output follows pending AND mask one clock later
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & mask)) |=> irq_out);
  a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & mask)) |=> !irq_out);

  // R5: set commands win
  a_r5_init_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && cwd[8]) |=> flags[0]);
  a_r5_init_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && cwd[7] && !cwd[8]) |=> !flags[0]);
  a_r5_xbus_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && cwd[10]) |=> flags[1]);
  a_r5_mreg_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && cwd[13]) |=> flags[2]);

  // R6: display clear without a coinciding edge
  a_r6_disp_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && cwd[11] && !(irq_req[DISP] && !$past(irq_req[DISP]))) |=> !pend[DISP]);

  // R7: mask stays put unless written
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel == SEL_MASK) |=> $stable(mask));

  // R11: unmapped reads return zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == 32'h0));

  // R8: a rising request edge latches pending
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_edge
    a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[i] && !$past(irq_req[i])) |=> pend[i]);
  end
endmodule

bind irq_regblk irq_regblk_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_wmask (bus_wmask),
  .bus_rdata (bus_rdata),
  .sel       (dec_sel),
  .irq_req   (irq_req),
  .pend      (pend_q),
  .mask      (mask_q),
  .flags     (mode_flags_q),
  .irq_out   (irq_out)
);

// File: tb/irq_regblk_tb.sv
`timescale 1ns/1ps
module irq_regblk_tb;
  localparam logic [31:0] BASE = 32'h0430_0000;
  localparam logic [31:0] VER  = 32'h0001_0000;
  localparam logic [31:0] A_MODE = BASE + 32'h0;
  localparam logic [31:0] A_VER  = BASE + 32'h4;
  localparam logic [31:0] A_PEND = BASE + 32'h8;
  localparam logic [31:0] A_MASK = BASE + 32'hC;

  logic        clk, rst_n;
  logic [31:0] bus_addr, bus_wdata, bus_wmask, bus_rdata;
  logic        bus_wr;
  logic [5:0]  irq_req;
  logic [4:0]  irq_ack;
  logic        irq_out;

  int n_chk, n_fail;
  bit done;

  irq_regblk #(.NUM_SRC(6), .BASE_ADDR(BASE), .VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    bus_wr = 1'b0;
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk);
    irq_req = p;
    @(negedge clk);
    irq_req = 6'h0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mask_word(input logic [5:0] m);
    logic [31:0] w = 32'h0;
    for (int i = 0; i < 6; i++) w[m[i] ? 2*i+1 : 2*i] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] flag_word(input logic [2:0] f);
    return (f[0] ? 32'h100 : 32'h080) | (f[1] ? 32'h400 : 32'h200) |
           (f[2] ? 32'h2000 : 32'h1000);
  endfunction

  // clear all pending bits: ack sources 0..4 and display clear together
  task automatic clear_all();
    @(negedge clk);
    irq_ack = 5'h1F;
    bus_addr = A_MODE; bus_wdata = 32'h800; bus_wmask = 32'hFFFF_FFFF; bus_wr = 1'b1;
    @(negedge clk);
    irq_ack = 5'h0; bus_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 32'h0; bus_wdata = 32'h0;
    bus_wmask = 32'h0; irq_req = 6'h0; irq_ack = 5'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_MODE, d); chk("R1 mode", d, 32'h0);
    rd(A_VER,  d); chk("R1 version", d, VER);
    rd(A_PEND, d); chk("R1 pending", d, 32'h0);
    rd(A_MASK, d); chk("R1 mask", d, 32'h0);
    chk("R1 irq_out", {31'h0, irq_out}, 32'h0);

    // R7 R8 R10 sweep: all mask patterns against all pending patterns
    for (int m = 0; m < 64; m++) begin
      wr(A_MASK, mask_word(6'(m)), 32'hFFFF_FFFF);
      rd(A_MASK, d); chk("R7 mask sweep", d, 32'(m));
      for (int p = 0; p < 64; p++) begin
        pulse(6'(p));
        rd(A_PEND, d); chk("R8 pending sweep", d, 32'(p));
        chk("R10 irq_out sweep", {31'h0, irq_out}, {31'h0, |(6'(p) & 6'(m))});
        clear_all();
        rd(A_PEND, d); chk("R9 R6 cleared", d, 32'h0);
        chk("R10 irq_out low", {31'h0, irq_out}, 32'h0);
      end
    end

    // R4 R5 R6 sweep: every command combination from every flag state
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 128; c++) begin
        logic [6:0] cb, low;
        logic [2:0] f, ef;
        f = 3'(s); cb = 7'(c);
        low = 7'((c * 37 + s * 5) & 32'h7F);
        wr(A_MODE, flag_word(f), 32'hFFFF_FFFF);
        pulse(6'h20);
        wr(A_MODE, {18'h0, cb, low}, 32'hFFFF_FFFF);
        ef[0] = (f[0] & ~cb[0]) | cb[1];
        ef[1] = (f[1] & ~cb[2]) | cb[3];
        ef[2] = (f[2] & ~cb[5]) | cb[6];
        rd(A_MODE, d); chk("R4 R5 mode sweep", d, {22'h0, ef, low});
        rd(A_PEND, d); chk("R6 display clear", d, {26'h0, ~cb[4], 5'h0});
      end
    end
    clear_all();

    // R3 write mask gates commands and data
    wr(A_MODE, 32'h2500, 32'hFFFF_FFFF);
    wr(A_MODE, 32'hFFFF_FFFF, 32'h0000_0080);
    rd(A_MODE, d); chk("R3 mode masked", d, 32'h300);
    wr(A_MASK, 32'hAAA, 32'hFFFF_FFFF);
    wr(A_MASK, 32'hFFFF_FFFF, 32'h0000_0001);
    rd(A_MASK, d); chk("R3 mask masked", d, 32'h3E);

    // R2 top address bits ignored
    rd(32'hE430_000C, d); chk("R2 mirror mask", d, 32'h3E);
    rd(32'h2430_0004, d); chk("R2 mirror version", d, VER);

    // R11 unmapped reads and ignored writes
    rd(BASE + 32'h10, d); chk("R11 unmapped read", d, 32'h0);
    rd(BASE + 32'h2, d);  chk("R11 misaligned read", d, 32'h0);
    wr(A_VER,  32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(A_PEND, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(BASE + 32'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(32'h0030_000C, 32'h555, 32'hFFFF_FFFF);
    rd(A_MODE, d); chk("R11 mode untouched", d, 32'h300);
    rd(A_MASK, d); chk("R11 mask untouched", d, 32'h3E);
    rd(A_PEND, d); chk("R11 pending untouched", d, 32'h0);
    rd(A_VER,  d); chk("R11 version fixed", d, VER);
    chk("R11 irq_out", {31'h0, irq_out}, 32'h0);

    // R9 edge coinciding with ack keeps bit set
    pulse(6'h01);
    @(negedge clk); irq_req = 6'h01; irq_ack = 5'h01;
    @(negedge clk); irq_ack = 5'h0;
    rd(A_PEND, d); chk("R9 edge beats ack", d, 32'h1);
    // R8 held level does not re-set after ack
    @(negedge clk); irq_ack = 5'h01;
    @(negedge clk); irq_ack = 5'h0;
    repeat (2) @(negedge clk);
    rd(A_PEND, d); chk("R8 held level", d, 32'h0);
    irq_req = 6'h0;

    // R6 display edge coinciding with clear keeps bit set
    @(negedge clk);
    irq_req = 6'h20;
    bus_addr = A_MODE; bus_wdata = 32'h800; bus_wmask = 32'hFFFF_FFFF; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; irq_req = 6'h0;
    rd(A_PEND, d); chk("R6 edge beats clear", d, 32'h20);
    @(negedge clk);
    chk("R10 display enabled", {31'h0, irq_out}, 32'h1);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule